// File: doc/BRIEF.md
# Chainable TDM Codec Slot Port

This block is the serial-side engine of an audio codec that sits as a slave on a shared time-division-multiplexed bus. The bus bit clock is the block clock. A frame-sync input and a time-slot-in pulse are also inputs. When time-slot-in is seen high on a rising edge, the block takes the following 16-bit slots at once. It receives a control word and a left and right playback sample. It returns either a status word or the contents of one indexed 8-bit register, followed by a left and right capture sample. During the final bit of its last slot it raises time-slot-out, so the next device in the chain can start.

Two slot maps are available, chosen per frame by the `two_wire` input at the moment the frame starts:
- **One-wire map** (`two_wire`=0): six slots run in sequence. The three input slots come first and the three output slots follow, so input and output can share a single wire.
- **Two-wire map** (`two_wire`=1): three slots carry input and output at the same time on separate pins.

The control word reaches a small bank of sixteen 8-bit registers. Three of the sixteen addresses have no storage behind them.

Top module: `tdm_codec_port`

## Requirements
- R1: After reset, `sdo_oe`, `tso` and `play_valid` are 0. Register i holds i*8'h11. The stored read-request flag is clear.
- R2: With `two_wire`=0 the block uses six slots. Slots 0 to 2 receive, in order, the control word, the left playback word and the right playback word. Slots 3 to 5 send, in order, the status/readback word, `cap_left` and `cap_right`. All words are MSB first. Input bits are sampled on the falling edge. Output bits change on the rising edge.
- R3: With `two_wire`=1 the block uses three slots. Slot n receives the same input word as in R2 and, during the same slot, sends the same output word as in R2.
- R4: If `tsi` is high on a rising edge while the block is idle, the next bit cell is bit 15 of slot 0. If `tsi` is high while a frame is in progress, it is ignored.
- R5: `tso` is high for exactly one bit cell: the LSB cell of the last slot used.
- R6: `sdo_oe` is high only during the block's own output slots. At all other times `sdo` is 0.
- R7: Control word layout: bit 14 is the read request, bit 13 is the write enable, bits 11:8 are the index, and bits 7:0 are the data. A write stores the data into the indexed register when the control slot completes.
- R8: The status word is {4'h0, index, 5'b0, reserved-write-rejected, write-done, 1'b1}. It describes the most recent complete control word. In the one-wire map, the status sent in slot 3 already reflects the control word of slot 0 of the same frame.
- R9: When the stored read request is set, the output status slot carries the readback word {4'b0100, index, register}. This uses the same layout as the control word, with bit 14 set.
- R10: Indices 11, 14 and 15 are reserved. Reading one of them returns the status word. Writing one of them changes no register and sets the rejected bit.
- R11: In the two-wire map, the output status slot is built from the read request and index of the previous frame's control word.
- R12: When the right playback slot completes, `play_left` and `play_right` hold the received words and `play_valid` pulses for one cycle.
- R13: If `fsync` is high on a rising edge during a frame, the frame is abandoned. There is no output slot, no `tso` and no `play_valid`, and any partly received control word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; aborts a frame in progress |
| tsi | input | 1 | Time-slot-in start pulse |
| two_wire | input | 1 | Slot map for the next frame (0 six slots, 1 three slots) |
| sdi | input | 1 | Serial data in |
| cap_left | input | 16 | Left capture sample to send |
| cap_right | input | 16 | Right capture sample to send |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| tso | output | 1 | Time-slot-out hand-off pulse |
| play_left | output | 16 | Last received left playback word |
| play_right | output | 16 | Last received right playback word |
| play_valid | output | 1 | One-cycle pulse when a playback pair lands |

## Verification
The hardest case to reach is the difference in timing between the two slot maps for the status slot. In the one-wire map, a write and a read request in the same control word show up in that same frame. In the two-wire map, the status slot leaves before the control word has arrived, so it must describe the frame before. The stimulus runs a write-plus-read frame in one-wire mode and then switches to two-wire mode. The first two-wire frame must return the readback set up by the last one-wire frame, and the second must return the register written in the first. A frame aborted by frame sync partway through the control slot is followed by a two-wire frame, which shows that the half-received word left the stored state untouched.

// File: rtl/tdm_port_pkg.sv
package tdm_port_pkg;

  localparam int WORD_W = 16;
  localparam int IDX_W  = 4;
  localparam int REG_W  = 8;

  typedef struct packed {
    logic             pad_hi;
    logic             rreq;
    logic             we;
    logic             pad_lo;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] data;
  } ctl_word_t;

  function automatic logic idx_reserved(input logic [IDX_W-1:0] idx);
    return (idx == 4'd11) || (idx == 4'd14) || (idx == 4'd15);
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic [IDX_W-1:0] idx,
                                                    input logic rejected,
                                                    input logic wrote);
    return {4'h0, idx, 5'b00000, rejected, wrote, 1'b1};
  endfunction

  function automatic logic [WORD_W-1:0] pack_readback(input logic [IDX_W-1:0] idx,
                                                      input logic [REG_W-1:0] val);
    return {4'b0100, idx, val};
  endfunction

  function automatic logic [REG_W-1:0] reg_reset_val(input int i);
    return REG_W'(i * 17);
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOT_W    = 16,
  parameter int SLOTS_SEQ = 6,
  parameter int SLOTS_PAR = 3,
  localparam int CNT_W    = $clog2(SLOT_W),
  localparam int SL_W     = $clog2(SLOTS_SEQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fsync,
  input  logic            tsi,
  input  logic            two_wire,
  output logic            busy,
  output logic [SL_W-1:0] slot,
  output logic [CNT_W-1:0] bitc,
  output logic            mode,
  output logic            nxt_busy,
  output logic [SL_W-1:0] nxt_slot,
  output logic [CNT_W-1:0] nxt_bit,
  output logic            nxt_mode,
  output logic            word_done,
  output logic            tso
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SLOT_W - 1);
  localparam logic [SL_W-1:0]  LAST_SEQ = SL_W'(SLOTS_SEQ - 1);
  localparam logic [SL_W-1:0]  LAST_PAR = SL_W'(SLOTS_PAR - 1);

  logic            busy_q, mode_q, tso_q;
  logic [SL_W-1:0] slot_q;
  logic [CNT_W-1:0] bit_q;
  logic            abort_w, start_w;
  logic [SL_W-1:0] last_slot;

  assign abort_w   = fsync && busy_q;
  assign start_w   = tsi && !busy_q;
  assign last_slot = mode_q ? LAST_PAR : LAST_SEQ;
  assign word_done = busy_q && (bit_q == LAST_BIT) && !abort_w;

  always_comb begin
    nxt_busy = busy_q;
    nxt_slot = slot_q;
    nxt_bit  = bit_q;
    nxt_mode = mode_q;
    if (abort_w) begin
      nxt_busy = 1'b0;
      nxt_slot = '0;
      nxt_bit  = '0;
    end else if (start_w) begin
      nxt_busy = 1'b1;
      nxt_slot = '0;
      nxt_bit  = '0;
      nxt_mode = two_wire;
    end else if (busy_q) begin
      if (bit_q == LAST_BIT) begin
        nxt_bit = '0;
        if (slot_q == last_slot) begin
          nxt_busy = 1'b0;
          nxt_slot = '0;
        end else begin
          nxt_slot = slot_q + 1'b1;
        end
      end else begin
        nxt_bit = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      slot_q <= '0;
      bit_q  <= '0;
      mode_q <= 1'b0;
      tso_q  <= 1'b0;
    end else begin
      busy_q <= nxt_busy;
      slot_q <= nxt_slot;
      bit_q  <= nxt_bit;
      mode_q <= nxt_mode;
      tso_q  <= nxt_busy && (nxt_bit == LAST_BIT) &&
                (nxt_slot == (nxt_mode ? LAST_PAR : LAST_SEQ));
    end
  end

  assign busy = busy_q;
  assign slot = slot_q;
  assign bitc = bit_q;
  assign mode = mode_q;
  assign tso  = tso_q;

  // R5
  tso_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tso_q |=> !tso_q);

  // R4
  start_on_tsi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tsi && !busy_q) |=> (busy_q && slot_q == '0 && bit_q == '0));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fsync && bit_q != LAST_BIT) |=> (busy_q && bit_q == $past(bit_q) + 1'b1));

  // R13
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && busy_q) |=> (!busy_q && !tso_q));

endmodule

// File: rtl/tdm_serdes.sv
module tdm_serdes #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  input  logic         rx_en,
  output logic [W-1:0] rx_word,
  input  logic         tx_load,
  input  logic [W-1:0] tx_word,
  input  logic         oe_next,
  output logic         sdo,
  output logic         sdo_oe
);
  logic         sdi_s;
  logic [W-1:0] rx_q, tx_q;
  logic         oe_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sdi_s <= 1'b0;
    else        sdi_s <= sdi;
  end

  assign rx_word = {rx_q[W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0;
      tx_q <= '0;
      oe_q <= 1'b0;
    end else begin
      if (rx_en) rx_q <= rx_word;
      if (tx_load)   tx_q <= tx_word;
      else if (oe_q) tx_q <= {tx_q[W-2:0], 1'b0};
      oe_q <= oe_next;
    end
  end

  assign sdo    = oe_q & tx_q[W-1];
  assign sdo_oe = oe_q;

endmodule

// File: rtl/tdm_reg_bank.sv
module tdm_reg_bank
  import tdm_port_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_strobe,
  input  logic [WORD_W-1:0] ctl_word,
  output logic [WORD_W-1:0] out_word
);
  ctl_word_t        cw;
  logic             rreq_q;
  logic [IDX_W-1:0] idx_q;
  logic [WORD_W-1:0] status_q;
  logic             cw_reserved;
  wire  logic [REG_W-1:0] bank [NUM_REGS];

  assign cw          = ctl_word_t'(ctl_word);
  assign cw_reserved = idx_reserved(cw.idx);

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (idx_reserved(IDX_W'(gi))) begin : g_hole
      assign bank[gi] = '0;
    end else begin : g_ff
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reg_reset_val(gi);
        else if (ctl_strobe && cw.we && cw.idx == IDX_W'(gi)) q <= cw.data;
      end
      assign bank[gi] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rreq_q   <= 1'b0;
      idx_q    <= '0;
      status_q <= pack_status('0, 1'b0, 1'b0);
    end else if (ctl_strobe) begin
      rreq_q   <= cw.rreq;
      idx_q    <= cw.idx;
      status_q <= pack_status(cw.idx, cw.we && cw_reserved, cw.we && !cw_reserved);
    end
  end

  assign out_word = (rreq_q && !idx_reserved(idx_q)) ?
                    pack_readback(idx_q, bank[idx_q]) : status_q;

  // R7
  write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_strobe && cw.we && !cw_reserved) |=> (bank[idx_q] == $past(cw.data)));

endmodule

// File: rtl/tdm_codec_port.sv
module tdm_codec_port
  import tdm_port_pkg::*;
#(
  parameter int SLOTS_SEQ = 6,
  parameter int SLOTS_PAR = 3,
  parameter int NUM_REGS  = 16,
  localparam int CNT_W    = $clog2(WORD_W),
  localparam int SL_W     = $clog2(SLOTS_SEQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              tsi,
  input  logic              two_wire,
  input  logic              sdi,
  input  logic [WORD_W-1:0] cap_left,
  input  logic [WORD_W-1:0] cap_right,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              tso,
  output logic [WORD_W-1:0] play_left,
  output logic [WORD_W-1:0] play_right,
  output logic              play_valid
);
  localparam logic [SL_W-1:0] PAR_N = SL_W'(SLOTS_PAR);

  logic             busy, mode, nxt_busy, nxt_mode, word_done;
  logic [SL_W-1:0]  slot, nxt_slot, out_sel;
  logic [CNT_W-1:0] bitc, nxt_bit;
  logic             in_slot, out_next, tx_load;
  logic             ctl_strobe, left_strobe, right_strobe;
  logic [WORD_W-1:0] rx_word, tx_word, stat_word;
  logic [WORD_W-1:0] pl_q, pr_q;
  logic             pv_q;

  tdm_slot_timer #(
    .SLOT_W(WORD_W), .SLOTS_SEQ(SLOTS_SEQ), .SLOTS_PAR(SLOTS_PAR)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .tsi(tsi), .two_wire(two_wire),
    .busy(busy), .slot(slot), .bitc(bitc), .mode(mode),
    .nxt_busy(nxt_busy), .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .nxt_mode(nxt_mode),
    .word_done(word_done), .tso(tso)
  );

  assign in_slot      = busy && (slot < PAR_N);
  assign ctl_strobe   = word_done && in_slot && (slot == SL_W'(0));
  assign left_strobe  = word_done && in_slot && (slot == SL_W'(1));
  assign right_strobe = word_done && in_slot && (slot == SL_W'(2));

  assign out_next = nxt_busy && (nxt_mode || nxt_slot >= PAR_N);
  assign tx_load  = out_next && (nxt_bit == '0);
  assign out_sel  = nxt_mode ? nxt_slot : nxt_slot - PAR_N;

  always_comb begin
    case (out_sel)
      SL_W'(0): tx_word = stat_word;
      SL_W'(1): tx_word = cap_left;
      default:  tx_word = cap_right;
    endcase
  end

  tdm_serdes #(.W(WORD_W)) u_serdes (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .rx_en(in_slot), .rx_word(rx_word),
    .tx_load(tx_load), .tx_word(tx_word), .oe_next(out_next),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  tdm_reg_bank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_strobe(ctl_strobe), .ctl_word(rx_word),
    .out_word(stat_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pl_q <= '0;
      pr_q <= '0;
      pv_q <= 1'b0;
    end else begin
      if (left_strobe)  pl_q <= rx_word;
      if (right_strobe) pr_q <= rx_word;
      pv_q <= right_strobe;
    end
  end

  assign play_left  = pl_q;
  assign play_right = pr_q;
  assign play_valid = pv_q;

  // R6
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (busy && (mode || slot >= PAR_N)));

  // R12
  play_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    play_valid |=> !play_valid);

endmodule

// File: tb/tdm_codec_port_test.sv
module tdm_codec_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0, tsi = 1'b0, two_wire = 1'b0, sdi = 1'b0;
  logic [15:0] cap_left = '0, cap_right = '0;
  logic        sdo, sdo_oe, tso, play_valid;
  logic [15:0] play_left, play_right;

  int errors = 0;
  int checks = 0;

  logic [15:0] q_w[$];
  string       q_t[$];

  logic [7:0]  m_regs [16];
  logic [15:0] m_status;
  logic        m_rreq;
  logic [3:0]  m_idx;

  always #4 clk = ~clk;

  tdm_codec_port uut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .tsi(tsi), .two_wire(two_wire),
    .sdi(sdi), .cap_left(cap_left), .cap_right(cap_right), .sdo(sdo),
    .sdo_oe(sdo_oe), .tso(tso), .play_left(play_left), .play_right(play_right),
    .play_valid(play_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_res(input logic [3:0] i);
    return (i == 4'd11) || (i == 4'd14) || (i == 4'd15);
  endfunction

  function automatic logic [15:0] m_word0();
    if (m_rreq && !m_res(m_idx)) return {4'h4, m_idx, m_regs[m_idx]};
    return m_status;
  endfunction

  task automatic m_apply(input logic [15:0] c);
    logic [3:0] i;
    logic       we;
    i  = c[11:8];
    we = c[13];
    if (we && !m_res(i)) m_regs[i] = c[7:0];
    m_status = {8'h00, 5'b0, 3'b001} | {4'h0, i, 8'h00} |
               {13'b0, we && m_res(i), we && !m_res(i), 1'b0};
    m_rreq = c[14];
    m_idx  = i;
  endtask

  // scoreboard monitor
  initial begin
    logic [15:0] sh;
    int n;
    n = 0;
    sh = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && sdo_oe === 1'b1) begin
        sh = {sh[14:0], sdo};
        n++;
        if (n == 16) begin
          n = 0;
          if (q_w.size() == 0) chk(1'b0, "R6 unexpected word", {16'h0, sh}, 32'h0);
          else begin
            logic [15:0] w;
            string t;
            w = q_w.pop_front();
            t = q_t.pop_front();
            chk(sh === w, t, {16'h0, sh}, {16'h0, w});
          end
        end
      end else n = 0;
    end
  end

  task automatic do_frame(input bit md, input logic [15:0] ctl, pl, pr, cl, cr,
                          input string tag0, input int extra_tsi);
    logic [15:0] w0;
    logic [15:0] words [3];
    int ncell, oe_bad, tso_bad, pv_bad;
    bit pv_ok;
    if (md) begin w0 = m_word0(); m_apply(ctl); end
    else    begin m_apply(ctl); w0 = m_word0(); end
    q_w.push_back(w0); q_t.push_back(tag0);
    q_w.push_back(cl); q_t.push_back(md ? "R3 left capture" : "R2 left capture");
    q_w.push_back(cr); q_t.push_back(md ? "R3 right capture" : "R2 right capture");
    words[0] = ctl; words[1] = pl; words[2] = pr;
    ncell = md ? 48 : 96;
    oe_bad = 0; tso_bad = 0; pv_bad = 0; pv_ok = 1'b0;
    @(posedge clk); #2;
    cap_left = cl; cap_right = cr; two_wire = md; tsi = 1'b1;
    for (int k = 0; k <= ncell; k++) begin
      @(posedge clk); #2;
      tsi = (k == extra_tsi);
      sdi = (k < 48) ? words[k / 16][15 - (k % 16)] : 1'b0;
      @(negedge clk); #1;
      if (sdo_oe !== (md ? (k < 48) : (k >= 48 && k < 96))) oe_bad++;
      if (tso !== (k == ncell - 1)) tso_bad++;
      if (k == 48) pv_ok = (play_valid === 1'b1) && (play_left === pl) && (play_right === pr);
      else if (play_valid !== 1'b0) pv_bad++;
    end
    chk(oe_bad == 0, "R6 output enable window", oe_bad, 0);
    chk(tso_bad == 0, "R5 tso on last LSB", tso_bad, 0);
    chk(pv_ok && pv_bad == 0, "R12 playback words", {play_left, play_right}, {pl, pr});
    repeat (3) @(posedge clk);
  endtask

  task automatic do_abort(input int at_cell);
    int bad;
    bad = 0;
    @(posedge clk); #2;
    two_wire = 1'b0; tsi = 1'b1;
    for (int k = 0; k <= 100; k++) begin
      @(posedge clk); #2;
      tsi = 1'b0;
      sdi = 1'b1;
      fsync = (k == at_cell);
      @(negedge clk); #1;
      if (sdo_oe !== 1'b0 || tso !== 1'b0 || play_valid !== 1'b0) bad++;
    end
    chk(bad == 0, "R13 aborted frame silent", bad, 0);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_regs[i] = m_res(4'(i)) ? 8'h00 : 8'(i * 17);
    m_status = 16'h0001;
    m_rreq = 1'b0;
    m_idx = 4'h0;
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk); #1;
    chk(sdo_oe === 1'b0, "R1 sdo_oe after reset", sdo_oe, 0);
    chk(tso === 1'b0, "R1 tso after reset", tso, 0);
    chk(play_valid === 1'b0, "R1 play_valid after reset", play_valid, 0);
    // R1 reset register value, R9 readback format
    do_frame(1'b0, 16'h4300, 16'h1111, 16'h2222, 16'h1234, 16'hBEEF, "R1 R9 reset readback", -1);
    // R8 status after plain control word
    do_frame(1'b0, 16'h0000, 16'h8001, 16'h7FFE, 16'hA5A5, 16'h5A5A, "R8 status", -1);
    // R7 write and same-frame readback
    do_frame(1'b0, 16'h65A5, 16'h0F0F, 16'hF0F0, 16'h0001, 16'h8000, "R7 write readback", -1);
    // R8 write-done bit in same frame
    do_frame(1'b0, 16'h25C3, 16'hCAFE, 16'hFACE, 16'hFFFF, 16'h0000, "R8 write status", -1);
    // R10 write to reserved index
    do_frame(1'b0, 16'h6BFF, 16'h1357, 16'h2468, 16'h3C3C, 16'hC3C3, "R10 reserved write", -1);
    do_frame(1'b0, 16'h4A00, 16'h0000, 16'h0000, 16'h0102, 16'h0304, "R10 neighbour 10", -1);
    do_frame(1'b0, 16'h4C00, 16'h0000, 16'h0000, 16'h0506, 16'h0708, "R10 neighbour 12", -1);
    do_frame(1'b0, 16'h4E00, 16'h0000, 16'h0000, 16'h090A, 16'h0B0C, "R10 reserved read", -1);
    // R4 tsi during a frame is ignored
    do_frame(1'b0, 16'h4500, 16'h4444, 16'h5555, 16'h6666, 16'h7777, "R4 mid-frame tsi", 30);
    // R11 two-wire status slot uses previous control word
    do_frame(1'b1, 16'h6733, 16'h1010, 16'h2020, 16'h3030, 16'h4040, "R11 prior readback", -1);
    do_frame(1'b1, 16'h0000, 16'h5050, 16'h6060, 16'h7070, 16'h8080, "R11 written value", -1);
    do_frame(1'b1, 16'h4100, 16'h9090, 16'hA0A0, 16'hB0B0, 16'hC0C0, "R3 status", 20);
    // R13 abort mid control slot, then confirm state untouched
    do_abort(10);
    do_frame(1'b1, 16'h0000, 16'hD0D0, 16'hE0E0, 16'hF0F0, 16'h0F0F, "R13 state after abort", -1);
    repeat (5) @(posedge clk);
    chk(q_w.size() == 0, "R2 all output words seen", q_w.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule